// File: doc/BRIEF.md
# Predicated vector compare-and-branch unit

This unit decides a conditional branch whose two source operands may each be a single scalar or a vector of elements. On a start request it captures a 3-bit comparison code, one scalar/vector flag per source, a vector length, a source predicate mask and an optional destination predicate register select. It then fetches operand elements through two index-addressed read ports, one element per clock, and compares each active element pair. Every comparison is recorded in a per-element result bitfield.

When neither source is a vector, the unit makes one ordinary comparison and takes the branch exactly when that comparison holds. When at least one source is a vector, the branch is taken only if every element left active by the source mask passes. The result bitfield can also be written into one of a small bank of predicate registers. Software builds "less or equal" and "greater than" by swapping the operands.

Top module: `vcmp_branch_unit`

## Requirements
- R1: With both vector flags low, one comparison is made between element 0 of each source. `taken` equals its outcome, `res_bits` is zero and no predicate register is written.
- R2: The comparison codes are 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than and 111 unsigned greater-or-equal. Codes 010 and 011 are reserved.
- R3: With at least one vector flag high, `taken` is 1 exactly when every element i < VL with `src_mask[i]`=1 passes. Elements whose mask bit is 0 do not affect the decision.
- R4: A source whose vector flag is low is always read at index 0, so its value is compared against every element of the other source. A vector source is read at index i for element i.
- R5: In the vector case, bit i of `res_bits` is 1 exactly when i < VL, `src_mask[i]`=1 and element i passes. All other bits are 0, because the bitfield is cleared when an operation starts.
- R6: If `dst_en` is 1 in the vector case, the result bitfield is written to predicate register `dst_sel`. Any register is readable on `pred_rd_data` one clock after `pred_rd_sel` is presented. If `dst_en` is 0, no predicate register changes.
- R7: A reserved code sets `illegal` to 1 and `taken` to 0. It makes `res_bits` zero, writes no predicate register, and raises `done` at the start edge.
- R8: In the vector case with VL=0, or with every element masked off, `taken` is 1 and the result bitfield is zero. With VL=0, `done` rises at the start edge.
- R9: `done` is a one-clock pulse. Counting the start edge as edge 1, it rises at edge 2 for a scalar operation and at edge VL+1 for a vector operation. A start request while `busy` is high is ignored.
- R10: After reset, `done`, `taken`, `illegal` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, accepted only when idle |
| func | input | 3 | Comparison code |
| a_vec | input | 1 | First source is a vector |
| b_vec | input | 1 | Second source is a vector |
| vl | input | $clog2(MAXVL+1) | Vector length |
| src_mask | input | MAXVL | Source predicate mask, one bit per element |
| dst_en | input | 1 | Write result to a predicate register |
| dst_sel | input | $clog2(NPRED) | Destination predicate register |
| rd_idx_a | output | $clog2(MAXVL) | Element index for first source |
| rd_idx_b | output | $clog2(MAXVL) | Element index for second source |
| rd_data_a | input | XLEN | First source element at `rd_idx_a`, same cycle |
| rd_data_b | input | XLEN | Second source element at `rd_idx_b`, same cycle |
| busy | output | 1 | Element loop in progress |
| done | output | 1 | One-clock completion pulse |
| taken | output | 1 | Branch decision, held until the next completion |
| illegal | output | 1 | Reserved code seen, held until the next completion |
| res_bits | output | MAXVL | Result bitfield, held until the next completion |
| pred_rd_sel | input | $clog2(NPRED) | Predicate register read select |
| pred_rd_data | output | MAXVL | Registered predicate register contents |

## Verification
The assertions assume that the element data returned on the read ports is settled within the cycle its index is shown, and that `vl` never exceeds MAXVL. The stimulus keeps VL in range and serves both read ports combinationally from bench arrays indexed by the unit's own index outputs. The stimulus also forces frequent equal and sign-straddling operand pairs, so that all six comparisons switch outcome. Predicate registers are compared only after the bench has written each of them once, since their power-up contents are undefined.

// File: rtl/vcb_pkg.sv
package vcb_pkg;
  localparam logic [2:0] FN_EQ  = 3'b000;
  localparam logic [2:0] FN_NE  = 3'b001;
  localparam logic [2:0] FN_LT  = 3'b100;
  localparam logic [2:0] FN_GE  = 3'b101;
  localparam logic [2:0] FN_LTU = 3'b110;
  localparam logic [2:0] FN_GEU = 3'b111;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

  function automatic logic fn_reserved(input logic [2:0] f);
    return f[2:1] == 2'b01;
  endfunction
endpackage

// File: rtl/vcb_elem_cmp.sv
module vcb_elem_cmp #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      func,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic            pass
);
  import vcb_pkg::*;

  logic eq, lts, ltu;

  always_comb begin
    eq  = op_a == op_b;
    lts = $signed(op_a) < $signed(op_b);
    ltu = op_a < op_b;
    case (func)
      FN_EQ:   pass = eq;
      FN_NE:   pass = !eq;
      FN_LT:   pass = lts;
      FN_GE:   pass = !lts;
      FN_LTU:  pass = ltu;
      FN_GEU:  pass = !ltu;
      default: pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/vcb_pred_bank.sv
module vcb_pred_bank #(
  parameter int MAXVL = 32,
  parameter int NPRED = 4,
  localparam int SW = (NPRED > 1) ? $clog2(NPRED) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SW-1:0]    wsel,
  input  logic [MAXVL-1:0] wdata,
  input  logic [SW-1:0]    rsel,
  output logic [MAXVL-1:0] rdata
);
  logic [MAXVL-1:0] mem [NPRED];

  always_ff @(posedge clk) begin
    if (we) mem[wsel] <= wdata;
    rdata <= mem[rsel];
  end
endmodule

// File: rtl/vcb_seq.sv
module vcb_seq #(
  parameter int MAXVL = 32,
  parameter int NPRED = 4,
  localparam int IW = $clog2(MAXVL),
  localparam int VW = $clog2(MAXVL + 1),
  localparam int SW = (NPRED > 1) ? $clog2(NPRED) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       func,
  input  logic             a_vec,
  input  logic             b_vec,
  input  logic [VW-1:0]    vl,
  input  logic [MAXVL-1:0] src_mask,
  input  logic             dst_en,
  input  logic [SW-1:0]    dst_sel,
  input  logic             pass,
  output logic [2:0]       func_q,
  output logic [IW-1:0]    idx_a,
  output logic [IW-1:0]    idx_b,
  output logic             busy,
  output logic             done,
  output logic             taken,
  output logic             illegal,
  output logic [MAXVL-1:0] res_bits,
  output logic             wr_en,
  output logic [SW-1:0]    wr_sel
);
  import vcb_pkg::*;

  seq_state_t       state;
  logic [IW-1:0]    idx;
  logic [VW-1:0]    vl_q;
  logic [MAXVL-1:0] mask_q, acc;
  logic             fail, vec_q, a_vec_q, b_vec_q, dst_en_q;
  logic             start_vec;
  logic [VW-1:0]    vl_clamp;
  logic             active, hit, last, fail_n;
  logic [MAXVL-1:0] acc_n;

  assign busy  = state == ST_RUN;
  assign idx_a = a_vec_q ? idx : '0;
  assign idx_b = b_vec_q ? idx : '0;

  always_comb begin
    start_vec = a_vec | b_vec;
    vl_clamp  = (vl > VW'(MAXVL)) ? VW'(MAXVL) : vl;
    active    = vec_q ? mask_q[idx] : 1'b1;
    hit       = active & pass;
    acc_n     = acc | (MAXVL'(hit) << idx);
    fail_n    = fail | (active & !pass);
    last      = !vec_q || (VW'(idx) == vl_q - VW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx      <= '0;
      vl_q     <= '0;
      mask_q   <= '0;
      acc      <= '0;
      fail     <= 1'b0;
      vec_q    <= 1'b0;
      a_vec_q  <= 1'b0;
      b_vec_q  <= 1'b0;
      dst_en_q <= 1'b0;
      func_q   <= '0;
      done     <= 1'b0;
      taken    <= 1'b0;
      illegal  <= 1'b0;
      res_bits <= '0;
      wr_en    <= 1'b0;
      wr_sel   <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          func_q   <= func;
          a_vec_q  <= a_vec;
          b_vec_q  <= b_vec;
          vec_q    <= start_vec;
          vl_q     <= vl_clamp;
          mask_q   <= src_mask;
          dst_en_q <= dst_en;
          wr_sel   <= dst_sel;
          idx      <= '0;
          acc      <= '0;
          fail     <= 1'b0;
          if (fn_reserved(func)) begin
            done     <= 1'b1;
            taken    <= 1'b0;
            illegal  <= 1'b1;
            res_bits <= '0;
          end else if (start_vec && vl_clamp == '0) begin
            done     <= 1'b1;
            taken    <= 1'b1;
            illegal  <= 1'b0;
            res_bits <= '0;
            wr_en    <= dst_en;
          end else begin
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          acc  <= acc_n;
          fail <= fail_n;
          if (last) begin
            state    <= ST_IDLE;
            done     <= 1'b1;
            illegal  <= 1'b0;
            taken    <= vec_q ? !fail_n : pass;
            res_bits <= vec_q ? acc_n : '0;
            wr_en    <= vec_q & dst_en_q;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a reserved code never yields a taken branch
  a_r7_illegal_not_taken: assert property (@(posedge clk) disable iff (rst)
    done && illegal |-> !taken);

  // R5: no result bit outside the captured source mask
  a_r5_res_within_mask: assert property (@(posedge clk) disable iff (rst)
    done |-> (res_bits & ~mask_q) == '0);

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: a scalar branch produces no bits and no predicate write
  a_r1_scalar_no_bits: assert property (@(posedge clk) disable iff (rst)
    done && !vec_q |-> res_bits == '0 && !wr_en);
endmodule

// File: rtl/vcmp_branch_unit.sv
module vcmp_branch_unit #(
  parameter int XLEN  = 32,
  parameter int MAXVL = 16,
  parameter int NPRED = 4,
  localparam int IW = $clog2(MAXVL),
  localparam int VW = $clog2(MAXVL + 1),
  localparam int SW = (NPRED > 1) ? $clog2(NPRED) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       func,
  input  logic             a_vec,
  input  logic             b_vec,
  input  logic [VW-1:0]    vl,
  input  logic [MAXVL-1:0] src_mask,
  input  logic             dst_en,
  input  logic [SW-1:0]    dst_sel,
  output logic [IW-1:0]    rd_idx_a,
  output logic [IW-1:0]    rd_idx_b,
  input  logic [XLEN-1:0]  rd_data_a,
  input  logic [XLEN-1:0]  rd_data_b,
  output logic             busy,
  output logic             done,
  output logic             taken,
  output logic             illegal,
  output logic [MAXVL-1:0] res_bits,
  input  logic [SW-1:0]    pred_rd_sel,
  output logic [MAXVL-1:0] pred_rd_data
);
  logic          pass;
  logic [2:0]    func_q;
  logic          wr_en;
  logic [SW-1:0] wr_sel;

  vcb_elem_cmp #(.XLEN(XLEN)) u_cmp (
    .func (func_q),
    .op_a (rd_data_a),
    .op_b (rd_data_b),
    .pass (pass)
  );

  vcb_seq #(.MAXVL(MAXVL), .NPRED(NPRED)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .func     (func),
    .a_vec    (a_vec),
    .b_vec    (b_vec),
    .vl       (vl),
    .src_mask (src_mask),
    .dst_en   (dst_en),
    .dst_sel  (dst_sel),
    .pass     (pass),
    .func_q   (func_q),
    .idx_a    (rd_idx_a),
    .idx_b    (rd_idx_b),
    .busy     (busy),
    .done     (done),
    .taken    (taken),
    .illegal  (illegal),
    .res_bits (res_bits),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel)
  );

  vcb_pred_bank #(.MAXVL(MAXVL), .NPRED(NPRED)) u_bank (
    .clk   (clk),
    .we    (wr_en),
    .wsel  (wr_sel),
    .wdata (res_bits),
    .rsel  (pred_rd_sel),
    .rdata (pred_rd_data)
  );

  // R7: an illegal operation never writes a predicate register
  a_r7_illegal_no_write: assert property (@(posedge clk) disable iff (rst)
    done && illegal |-> !wr_en);
endmodule

// File: tb/vcmp_branch_unit_tb_top.sv
module vcmp_branch_unit_tb_top;
  localparam int XLEN = 32, MAXVL = 16, NPRED = 4;
  localparam int IW = $clog2(MAXVL), VW = $clog2(MAXVL + 1), SW = $clog2(NPRED);

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, a_vec = 1'b0, b_vec = 1'b0, dst_en = 1'b0;
  logic [2:0] func = '0;
  logic [VW-1:0] vl = '0;
  logic [MAXVL-1:0] src_mask = '0;
  logic [SW-1:0] dst_sel = '0, pred_rd_sel = '0;
  logic [IW-1:0] rd_idx_a, rd_idx_b;
  logic [XLEN-1:0] rd_data_a, rd_data_b;
  logic busy, done, taken, illegal;
  logic [MAXVL-1:0] res_bits, pred_rd_data;

  logic [XLEN-1:0] mem_a [MAXVL];
  logic [XLEN-1:0] mem_b [MAXVL];
  logic [MAXVL-1:0] shadow [NPRED];
  logic [NPRED-1:0] shadow_ok = '0;

  int checks = 0, failures = 0, cycles = 0;

  always #2 clk = ~clk;

  always_comb begin
    rd_data_a = mem_a[rd_idx_a];
    rd_data_b = mem_b[rd_idx_b];
  end

  vcmp_branch_unit #(.XLEN(XLEN), .MAXVL(MAXVL), .NPRED(NPRED)) dut_i (
    .clk(clk), .rst(rst), .start(start), .func(func), .a_vec(a_vec), .b_vec(b_vec),
    .vl(vl), .src_mask(src_mask), .dst_en(dst_en), .dst_sel(dst_sel),
    .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b), .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .busy(busy), .done(done), .taken(taken), .illegal(illegal), .res_bits(res_bits),
    .pred_rd_sel(pred_rd_sel), .pred_rd_data(pred_rd_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic ref_cmp(input logic [2:0] f, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    case (f)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return $signed(a) < $signed(b);
      3'b101: return $signed(a) >= $signed(b);
      3'b110: return a < b;
      3'b111: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_bank(input string tag);
    @(posedge clk);
    for (int s = 0; s < NPRED; s++) begin
      @(negedge clk);
      pred_rd_sel = SW'(s);
      @(posedge clk);
      @(negedge clk);
      if (shadow_ok[s]) chk(tag, pred_rd_data, shadow[s]);
    end
  endtask

  task automatic run_op(input logic [2:0] f, input logic av, input logic bv, input int n,
                        input logic [MAXVL-1:0] m, input logic de, input logic [SW-1:0] ds,
                        input logic poke);
    logic vec, e_ill, e_tak;
    logic [MAXVL-1:0] e_res;
    int e_lat, lat;
    vec   = av | bv;
    e_ill = (f[2:1] == 2'b01);
    e_res = '0;
    e_tak = 1'b1;
    if (e_ill) begin
      e_tak = 1'b0; e_lat = 1;
    end else if (!vec) begin
      e_tak = ref_cmp(f, mem_a[0], mem_b[0]); e_lat = 2;
    end else begin
      e_lat = (n == 0) ? 1 : n + 1;
      for (int i = 0; i < n; i++) begin
        logic p;
        p = ref_cmp(f, av ? mem_a[i] : mem_a[0], bv ? mem_b[i] : mem_b[0]);
        if (m[i]) begin
          if (p) e_res[i] = 1'b1;
          else   e_tak = 1'b0;
        end
      end
    end
    @(negedge clk);
    func = f; a_vec = av; b_vec = bv; vl = VW'(n); src_mask = m;
    dst_en = de; dst_sel = ds; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      if (poke && lat == 2) begin
        chk("R9 busy", busy, 1'b1);
        start = 1'b1; func = f ^ 3'b001; src_mask = ~m; a_vec = 1'b0; b_vec = 1'b0;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk("R9 done", done, 1'b1);
    chk("R9 latency", 64'(lat), 64'(e_lat));
    chk("R7 illegal", illegal, e_ill);
    chk(vec ? "R3 taken" : "R1 taken", taken, e_tak);
    chk(vec ? "R5 res_bits" : "R1 res_bits", res_bits, e_res);
    @(posedge clk);
    @(negedge clk);
    chk("R9 done_pulse", done, 1'b0);
    if (vec && !e_ill && de) begin
      shadow[ds] = e_res;
      shadow_ok[ds] = 1'b1;
    end
    check_bank(de ? "R6 bank" : "R6 bank_untouched");
  endtask

  task automatic fill(input int mode);
    for (int i = 0; i < MAXVL; i++) begin
      logic [XLEN-1:0] v;
      v = $urandom;
      case (mode)
        0: begin mem_a[i] = v; mem_b[i] = v; end
        default: begin
          mem_a[i] = ($urandom % 2) ? v : XLEN'($signed($urandom % 5) - 2);
          mem_b[i] = ($urandom % 3 == 0) ? mem_a[i] : (($urandom % 2) ? $urandom : XLEN'($signed($urandom % 5) - 2));
        end
      endcase
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    fill(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10 done", done, 1'b0);
    chk("R10 taken", taken, 1'b0);
    chk("R10 illegal", illegal, 1'b0);
    chk("R10 busy", busy, 1'b0);

    // R6: give every predicate register a known value
    for (int s = 0; s < NPRED; s++) begin
      fill(1);
      run_op(3'b000, 1'b1, 1'b1, 16, 16'hffff, 1'b1, SW'(s), 1'b0);
    end

    // R1, R2: scalar branch for every code, equal and unequal operands
    for (int f = 0; f < 8; f++) begin
      if (f == 2 || f == 3) continue;
      mem_a[0] = 32'hffff_fff0; mem_b[0] = 32'h0000_0005;
      run_op(3'(f), 1'b0, 1'b0, 7, 16'hffff, 1'b1, 2'd1, 1'b0);
      mem_b[0] = mem_a[0];
      run_op(3'(f), 1'b0, 1'b0, 7, 16'hffff, 1'b0, 2'd0, 1'b0);
    end

    // R7: reserved codes with a destination enabled
    fill(1);
    run_op(3'b010, 1'b1, 1'b1, 9, 16'hffff, 1'b1, 2'd2, 1'b0);
    run_op(3'b011, 1'b0, 1'b0, 1, 16'hffff, 1'b1, 2'd3, 1'b0);

    // R8: zero length, and every element masked off
    run_op(3'b000, 1'b1, 1'b0, 0, 16'hffff, 1'b1, 2'd0, 1'b0);
    run_op(3'b110, 1'b1, 1'b1, 12, 16'h0000, 1'b1, 2'd1, 1'b0);

    // R3, R5: failing element masked out keeps the branch taken
    fill(0);
    mem_b[3] = mem_a[3] + 1;
    run_op(3'b000, 1'b1, 1'b1, 8, 16'hfff7, 1'b1, 2'd2, 1'b0);
    run_op(3'b000, 1'b1, 1'b1, 8, 16'hffff, 1'b1, 2'd2, 1'b0);

    // R4: scalar second source broadcast against a vector
    for (int i = 0; i < MAXVL; i++) mem_a[i] = 32'(i);
    mem_b[0] = 32'd6;
    run_op(3'b110, 1'b1, 1'b0, 16, 16'hffff, 1'b1, 2'd3, 1'b0);
    run_op(3'b101, 1'b0, 1'b1, 16, 16'hffff, 1'b0, 2'd0, 1'b0);

    // R9: start while busy is ignored
    fill(1);
    run_op(3'b100, 1'b1, 1'b1, 10, 16'h5a5a, 1'b1, 2'd0, 1'b1);

    // R2, R3, R5, R6: random operations
    for (int k = 0; k < 150; k++) begin
      logic [2:0] f;
      fill(($urandom % 4 == 0) ? 0 : 1);
      f = 3'($urandom);
      if (f[2:1] == 2'b01 && ($urandom % 4 != 0)) f[2] = 1'b1;
      run_op(f, 1'($urandom), 1'($urandom), int'($urandom % (MAXVL + 1)),
             ($urandom % 3 == 0) ? 16'hffff : 16'($urandom),
             1'($urandom), SW'($urandom), 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule